// File: doc/BRIEF.md
# Dual-port inter-processor mailbox FIFO

This block connects two processors that run on one clock with a pair of message queues, one per direction. Each processor sees three registers on its own register bus. A write to its transmit register appends a word to its outbound queue. A read of its receive register takes a word from its inbound queue. A control/status register holds the enables, the sticky error flag, a flush strobe and the queue status. The outbound queue of side A is the inbound queue of side B, and the reverse also holds. Messages therefore flow in both directions at once and never pass each other.

Each side has two interrupt outputs. The send interrupt tells the writer that every word it queued has been consumed. The receive interrupt tells the reader that its inbound queue has just gained data. Both are one-cycle pulses raised on a change of queue state. A write to a full queue drops the word, and a read of an empty queue pops nothing. Both raise a sticky error flag, which software clears by writing a 1 to it. Software on the receiving side is expected to keep reading until the receive-empty status bit is set, because no new receive interrupt arrives while data is still waiting.

Top module: `mbox_duplex`

## Requirements
- R1: After reset both queues are empty, both interrupt outputs are low, and each control register reads 0x0000_00A0 (only send-empty and receive-empty set).
- R2: The register map on each side is: address 0 control/status, address 1 transmit, address 2 receive. A read of address 3 returns zero. Each queue holds DEPTH (16) words of 32 bits. The words written at one side's address 1 are returned in the same order by reads of the other side's address 2.
- R3: A transmit write while the outbound queue holds DEPTH words stores nothing and sets the error bit (control bit 3).
- R4: A receive read while the inbound queue is empty does not pop. It returns the most recently popped word (zero if none) and sets the error bit.
- R5: The error bit stays set until a control write with bit 3 = 1. Writing 0 there leaves it unchanged.
- R6: Control read-back: bit 0 channel enable, bit 1 send-interrupt enable, bit 2 receive-interrupt enable, bit 3 error, bit 4 reads 0, bit 5 outbound queue empty, bit 6 outbound queue full, bit 7 inbound queue empty.
- R7: The receive interrupt is a one-cycle pulse in the cycle after the inbound queue goes from empty to not empty, while bits 0 and 2 are set. It is not raised again while the queue stays non-empty.
- R8: The send interrupt is a one-cycle pulse in the cycle after the outbound queue becomes empty (by the last pop or by a flush), while bits 0 and 1 are set.
- R9: Setting an interrupt's enable bits while its condition already holds produces exactly one pulse, in the cycle after the control write.
- R10: While bit 0 is 0, transmit writes are dropped, receive reads return zero without popping or setting the error bit, and neither interrupt pulses.
- R11: A control write with bit 4 = 1 empties that side's outbound queue at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_en | input | 1 | Side A register write strobe |
| a_rd_en | input | 1 | Side A register read strobe |
| a_addr | input | 2 | Side A register address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for the addressed register, valid in the same cycle |
| a_irq_send | output | 1 | Side A send-empty interrupt pulse |
| a_irq_recv | output | 1 | Side A receive-not-empty interrupt pulse |
| b_wr_en | input | 1 | Side B register write strobe |
| b_rd_en | input | 1 | Side B register read strobe |
| b_addr | input | 2 | Side B register address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data for the addressed register, valid in the same cycle |
| b_irq_send | output | 1 | Side B send-empty interrupt pulse |
| b_irq_recv | output | 1 | Side B receive-not-empty interrupt pulse |

## Verification
The assertions assume that each side raises at most one of its read and write strobes in any cycle. The error check also relies on this: it does not expect a set and a clear of the error flag in the same cycle. The bench drives every access through one task that takes a single operation per side per cycle, so the two strobes are never high together. The two sides may still act in the same cycle, so a pop can meet a push or a flush on the same queue. The random phase exercises these collisions against the reference model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Register selects on each side's bus
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TX   = 2'd1,
        SEL_RX   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Sticky error tracking
    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_e;

    // Control/status bit positions
    localparam int CTL_EN     = 0;
    localparam int CTL_SIE    = 1;
    localparam int CTL_RIE    = 2;
    localparam int CTL_ERR    = 3;
    localparam int CTL_FLUSH  = 4;
    localparam int ST_TXEMPTY = 5;
    localparam int ST_TXFULL  = 6;
    localparam int ST_RXEMPTY = 7;

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mbox_irq_edge.sv
module mbox_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign pulse = level & ~level_q;

endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic             tx_empty,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic [WIDTH-1:0] rx_head,
    output logic             push,
    output logic [WIDTH-1:0] push_data,
    output logic             pop,
    output logic             flush,
    output logic             irq_send,
    output logic             irq_recv,
    output logic             en_o,
    output logic             err_o
);

    reg_sel_e         sel;
    err_state_e       err_st;
    err_state_e       err_nx;
    logic             en;
    logic             sie;
    logic             rie;
    logic [WIDTH-1:0] last_rx;
    logic             wr_ctrl;
    logic             wr_tx;
    logic             rd_rx;
    logic             overflow;
    logic             underflow;
    logic             send_lvl;
    logic             recv_lvl;

    assign sel       = reg_sel_e'(addr);
    assign wr_ctrl   = wr_en & (sel == SEL_CTRL);
    assign wr_tx     = wr_en & (sel == SEL_TX);
    assign rd_rx     = rd_en & (sel == SEL_RX);

    assign push      = wr_tx & en & ~tx_full;
    assign push_data = wdata;
    assign overflow  = wr_tx & en & tx_full;
    assign pop       = rd_rx & en & ~rx_empty;
    assign underflow = rd_rx & en & rx_empty;
    assign flush     = wr_ctrl & wdata[CTL_FLUSH];

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            sie <= 1'b0;
            rie <= 1'b0;
        end else if (wr_ctrl) begin
            en  <= wdata[CTL_EN];
            sie <= wdata[CTL_SIE];
            rie <= wdata[CTL_RIE];
        end
    end

    // Last word taken from the inbound queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rx <= '0;
        end else if (pop) begin
            last_rx <= rx_head;
        end
    end

    // Error state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_st <= ERR_CLEAR;
        end else begin
            err_st <= err_nx;
        end
    end

    // Error transitions: CLEAR->HELD on fault, HELD->CLEAR on write-1
    always_comb begin
        err_nx = err_st;
        unique case (err_st)
            ERR_CLEAR: if (overflow | underflow)         err_nx = ERR_HELD;
            ERR_HELD:  if (wr_ctrl & wdata[CTL_ERR])    err_nx = ERR_CLEAR;
        endcase
    end

    // Read-data output process
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                rdata[CTL_EN]     = en;
                rdata[CTL_SIE]    = sie;
                rdata[CTL_RIE]    = rie;
                rdata[CTL_ERR]    = (err_st == ERR_HELD);
                rdata[ST_TXEMPTY] = tx_empty;
                rdata[ST_TXFULL]  = tx_full;
                rdata[ST_RXEMPTY] = rx_empty;
            end
            SEL_RX: begin
                if (en) begin
                    rdata = rx_empty ? last_rx : rx_head;
                end
            end
            SEL_TX, SEL_NONE: rdata = '0;
        endcase
    end

    assign send_lvl = en & sie & tx_empty;
    assign recv_lvl = en & rie & ~rx_empty;

    mbox_irq_edge i_send_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (send_lvl),
        .pulse (irq_send)
    );

    mbox_irq_edge i_recv_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (recv_lvl),
        .pulse (irq_recv)
    );

    assign en_o  = en;
    assign err_o = (err_st == ERR_HELD);

endmodule

// File: rtl/mbox_duplex.sv
module mbox_duplex #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic              a_rd_en,
    input  logic [1:0]        a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_send,
    output logic              a_irq_recv,
    input  logic              b_wr_en,
    input  logic              b_rd_en,
    input  logic [1:0]        b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_send,
    output logic              b_irq_recv
);

    logic              wr_v      [2];
    logic              rd_v      [2];
    logic [1:0]        addr_v    [2];
    logic [DATA_W-1:0] wdata_v   [2];
    logic [DATA_W-1:0] rdata_v   [2];
    logic [DATA_W-1:0] head_v    [2];
    logic [DATA_W-1:0] pdata_v   [2];
    logic              push_v    [2];
    logic              pop_v     [2];
    logic              flush_v   [2];
    logic              empty_v   [2];
    logic              full_v    [2];
    logic              isend_v   [2];
    logic              irecv_v   [2];
    logic [1:0]        side_en;
    logic [1:0]        side_err;
    logic [1:0][CW-1:0] q_cnt;

    assign wr_v[0]    = a_wr_en;
    assign rd_v[0]    = a_rd_en;
    assign addr_v[0]  = a_addr;
    assign wdata_v[0] = a_wdata;
    assign wr_v[1]    = b_wr_en;
    assign rd_v[1]    = b_rd_en;
    assign addr_v[1]  = b_addr;
    assign wdata_v[1] = b_wdata;

    assign a_rdata    = rdata_v[0];
    assign a_irq_send = isend_v[0];
    assign a_irq_recv = irecv_v[0];
    assign b_rdata    = rdata_v[1];
    assign b_irq_send = isend_v[1];
    assign b_irq_recv = irecv_v[1];

    // Queue s carries words written by side s to side (1-s)
    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int PEER = 1 - s;

        mbox_queue #(
            .WIDTH (DATA_W),
            .DEPTH (DEPTH)
        ) i_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[s]),
            .push_data (pdata_v[s]),
            .pop       (pop_v[PEER]),
            .flush     (flush_v[s]),
            .head      (head_v[s]),
            .count     (q_cnt[s]),
            .empty     (empty_v[s]),
            .full      (full_v[s])
        );

        mbox_side #(
            .WIDTH (DATA_W)
        ) i_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_v[s]),
            .rd_en     (rd_v[s]),
            .addr      (addr_v[s]),
            .wdata     (wdata_v[s]),
            .rdata     (rdata_v[s]),
            .tx_empty  (empty_v[s]),
            .tx_full   (full_v[s]),
            .rx_empty  (empty_v[PEER]),
            .rx_head   (head_v[PEER]),
            .push      (push_v[s]),
            .push_data (pdata_v[s]),
            .pop       (pop_v[s]),
            .flush     (flush_v[s]),
            .irq_send  (isend_v[s]),
            .irq_recv  (irecv_v[s]),
            .en_o      (side_en[s]),
            .err_o     (side_err[s])
        );
    end

endmodule

// File: rtl/mbox_duplex_chk.sv
module mbox_duplex_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CW     = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               a_wr_en,
    input logic               a_rd_en,
    input logic [1:0]         a_addr,
    input logic [DATA_W-1:0]  a_wdata,
    input logic [DATA_W-1:0]  a_rdata,
    input logic               a_irq_send,
    input logic               a_irq_recv,
    input logic               b_wr_en,
    input logic               b_rd_en,
    input logic [1:0]         b_addr,
    input logic [DATA_W-1:0]  b_wdata,
    input logic [DATA_W-1:0]  b_rdata,
    input logic               b_irq_send,
    input logic               b_irq_recv,
    input logic [1:0]         side_en,
    input logic [1:0]         side_err,
    input logic [1:0][CW-1:0] q_cnt
);

    assert_recv_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq_recv |=> !a_irq_recv);

    assert_recv_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq_recv |-> (q_cnt[0] != '0));

    assert_send_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq_send |=> !b_irq_send);

    assert_send_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq_send |-> (q_cnt[0] == '0));

    assert_overflow_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_addr == 2'd1 && side_en[0] && q_cnt[0] == CW'(DEPTH)) |=> side_err[0]);

    assert_underflow_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd_en && b_addr == 2'd2 && side_en[1] && q_cnt[0] == '0) |=> side_err[1]);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (side_err[1] && !(b_wr_en && b_addr == 2'd0 && b_wdata[3])) |=> side_err[1]);

    assert_off_rx_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && a_addr == 2'd2 && !side_en[0]) |-> (a_rdata == '0));

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !side_en[1] |-> (!b_irq_send && !b_irq_recv));

endmodule

bind mbox_duplex mbox_duplex_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CW     (CW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_wr_en    (a_wr_en),
    .a_rd_en    (a_rd_en),
    .a_addr     (a_addr),
    .a_wdata    (a_wdata),
    .a_rdata    (a_rdata),
    .a_irq_send (a_irq_send),
    .a_irq_recv (a_irq_recv),
    .b_wr_en    (b_wr_en),
    .b_rd_en    (b_rd_en),
    .b_addr     (b_addr),
    .b_wdata    (b_wdata),
    .b_rdata    (b_rdata),
    .b_irq_send (b_irq_send),
    .b_irq_recv (b_irq_recv),
    .side_en    (side_en),
    .side_err   (side_err),
    .q_cnt      (q_cnt)
);

// File: tb/test_mbox_duplex.sv
module test_mbox_duplex;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    // bench operation codes
    localparam int OP_IDLE = 0;
    localparam int OP_WCTL = 1;
    localparam int OP_WTX  = 2;
    localparam int OP_RCTL = 3;
    localparam int OP_RRX  = 4;
    localparam int OP_R3   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr_en = 1'b0, a_rd_en = 1'b0;
    logic [1:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic        a_irq_send, a_irq_recv;
    logic        b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [1:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        b_irq_send, b_irq_recv;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model
    logic [31:0] q_ab[$];
    logic [31:0] q_ba[$];
    bit          m_en[2], m_sie[2], m_rie[2], m_err[2];
    logic [31:0] m_last[2];
    bit          lv_se[2], lv_rn[2];
    bit          x_se[2], x_rn[2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbox_duplex i_mbox_duplex (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_wr_en    (a_wr_en),
        .a_rd_en    (a_rd_en),
        .a_addr     (a_addr),
        .a_wdata    (a_wdata),
        .a_rdata    (a_rdata),
        .a_irq_send (a_irq_send),
        .a_irq_recv (a_irq_recv),
        .b_wr_en    (b_wr_en),
        .b_rd_en    (b_rd_en),
        .b_addr     (b_addr),
        .b_wdata    (b_wdata),
        .b_rdata    (b_rdata),
        .b_irq_send (b_irq_send),
        .b_irq_recv (b_irq_recv)
    );

    function automatic int tx_sz(input int s);
        return (s == 0) ? q_ab.size() : q_ba.size();
    endfunction

    function automatic int rx_sz(input int s);
        return (s == 0) ? q_ba.size() : q_ab.size();
    endfunction

    function automatic logic [31:0] rx_front(input int s);
        return (s == 0) ? q_ba[0] : q_ab[0];
    endfunction

    function automatic logic [31:0] exp_read(input int s, input int op);
        logic [31:0] v = '0;
        if (op == OP_RCTL) begin
            v[0] = m_en[s]; v[1] = m_sie[s]; v[2] = m_rie[s]; v[3] = m_err[s];
            v[5] = (tx_sz(s) == 0);
            v[6] = (tx_sz(s) == DEPTH);
            v[7] = (rx_sz(s) == 0);
        end else if (op == OP_RRX && m_en[s]) begin
            v = (rx_sz(s) == 0) ? m_last[s] : rx_front(s);
        end
        return v;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // interrupt comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7", "a_irq_recv", {31'b0, a_irq_recv}, {31'b0, x_rn[0]});
            check("R7", "b_irq_recv", {31'b0, b_irq_recv}, {31'b0, x_rn[1]});
            check("R8", "a_irq_send", {31'b0, a_irq_send}, {31'b0, x_se[0]});
            check("R8", "b_irq_send", {31'b0, b_irq_send}, {31'b0, x_se[1]});
        end
    end

    task automatic drive(input int s, input int op, input logic [31:0] d);
        logic we = (op == OP_WCTL || op == OP_WTX);
        logic re = (op == OP_RCTL || op == OP_RRX || op == OP_R3);
        logic [1:0] ad = (op == OP_WTX) ? 2'd1 : (op == OP_RRX) ? 2'd2 : (op == OP_R3) ? 2'd3 : 2'd0;
        if (s == 0) begin
            a_wr_en = we; a_rd_en = re; a_addr = ad; a_wdata = d;
        end else begin
            b_wr_en = we; b_rd_en = re; b_addr = ad; b_wdata = d;
        end
    endtask

    task automatic step(input int op_a, input logic [31:0] d_a,
                        input int op_b, input logic [31:0] d_b, input string req);
        int          op[2];
        logic [31:0] d[2];
        bit          pop[2], push[2], fault[2], fl[2];
        op[0] = op_a; op[1] = op_b; d[0] = d_a; d[1] = d_b;
        @(negedge clk);
        drive(0, op_a, d_a);
        drive(1, op_b, d_b);
        #1;
        for (int s = 0; s < 2; s++) begin
            if (op[s] == OP_RCTL || op[s] == OP_RRX || op[s] == OP_R3) begin
                check(req, (s == 0) ? "a_rdata" : "b_rdata",
                      (s == 0) ? a_rdata : b_rdata, exp_read(s, op[s]));
            end
        end
        for (int s = 0; s < 2; s++) begin
            pop[s]   = (op[s] == OP_RRX) && m_en[s] && rx_sz(s) > 0;
            push[s]  = (op[s] == OP_WTX) && m_en[s] && tx_sz(s) < DEPTH;
            fault[s] = ((op[s] == OP_WTX) && m_en[s] && tx_sz(s) == DEPTH) ||
                       ((op[s] == OP_RRX) && m_en[s] && rx_sz(s) == 0);
            fl[s]    = (op[s] == OP_WCTL) && d[s][4];
        end
        @(posedge clk);
        #1;
        if (pop[0]) m_last[0] = q_ba.pop_front();
        if (pop[1]) m_last[1] = q_ab.pop_front();
        if (push[0]) q_ab.push_back(d[0]);
        if (push[1]) q_ba.push_back(d[1]);
        if (fl[0]) q_ab.delete();
        if (fl[1]) q_ba.delete();
        for (int s = 0; s < 2; s++) begin
            bit nse, nrn;
            if (op[s] == OP_WCTL) begin
                m_en[s] = d[s][0]; m_sie[s] = d[s][1]; m_rie[s] = d[s][2];
                if (d[s][3]) m_err[s] = 1'b0;
            end
            if (fault[s]) m_err[s] = 1'b1;
            nse = m_en[s] && m_sie[s] && tx_sz(s) == 0;
            nrn = m_en[s] && m_rie[s] && rx_sz(s) != 0;
            x_se[s] = nse && !lv_se[s];
            x_rn[s] = nrn && !lv_rn[s];
            lv_se[s] = nse;
            lv_rn[s] = nrn;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_en[s] = 0; m_sie[s] = 0; m_rie[s] = 0; m_err[s] = 0; m_last[s] = '0;
            lv_se[s] = 0; lv_rn[s] = 0; x_se[s] = 0; x_rn[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset read-back
        step(OP_RCTL, 0, OP_RCTL, 0, "R1");
        // R10: disabled side drops writes and reads zero
        step(OP_WTX, 32'h11, OP_RRX, 0, "R10");
        step(OP_RCTL, 0, OP_RCTL, 0, "R10");
        // R2: address 3 reads zero
        step(OP_R3, 0, OP_R3, 0, "R2");

        // R7: enable, then A sends three words to B
        step(OP_WCTL, 32'h1, OP_WCTL, 32'h5, "R7");
        for (int i = 0; i < 3; i++) step(OP_WTX, 32'hA000 + i, OP_IDLE, 0, "R7");
        step(OP_WCTL, 32'h3, OP_RCTL, 0, "R6");
        // R2 / R8: B drains in order, A sees send-empty
        for (int i = 0; i < 3; i++) step(OP_RCTL, 0, OP_RRX, 0, "R2");
        step(OP_IDLE, 0, OP_RCTL, 0, "R6");
        // R4: empty read repeats last word and flags error
        step(OP_IDLE, 0, OP_RRX, 0, "R4");
        step(OP_IDLE, 0, OP_RCTL, 0, "R4");
        // R5: error persists, cleared only by write-1
        step(OP_IDLE, 0, OP_WCTL, 32'h5, "R5");
        step(OP_IDLE, 0, OP_RCTL, 0, "R5");
        step(OP_IDLE, 0, OP_WCTL, 32'hD, "R5");
        step(OP_IDLE, 0, OP_RCTL, 0, "R5");

        // R3: fill to DEPTH, then one more
        for (int i = 0; i < DEPTH; i++) step(OP_WTX, 32'hB000 + i, OP_IDLE, 0, "R3");
        step(OP_RCTL, 0, OP_IDLE, 0, "R6");
        step(OP_WTX, 32'hDEAD, OP_IDLE, 0, "R3");
        step(OP_RCTL, 0, OP_IDLE, 0, "R3");
        for (int i = 0; i < DEPTH + 1; i++) step(OP_IDLE, 0, OP_RRX, 0, "R3");
        step(OP_WCTL, 32'hB, OP_WCTL, 32'hD, "R5");

        // R9: enable receive interrupt after data already waits
        step(OP_IDLE, 0, OP_WCTL, 32'h1, "R9");
        step(OP_WTX, 32'hC1, OP_IDLE, 0, "R9");
        step(OP_WTX, 32'hC2, OP_IDLE, 0, "R9");
        step(OP_IDLE, 0, OP_WCTL, 32'h5, "R9");
        step(OP_IDLE, 0, OP_RCTL, 0, "R9");
        // R11: flush with data pending fires send-empty on A
        step(OP_WCTL, 32'h13, OP_IDLE, 0, "R11");
        step(OP_RCTL, 0, OP_RCTL, 0, "R11");
        step(OP_IDLE, 0, OP_RRX, 0, "R11");
        // R10: disabled reader keeps data and reads zero
        step(OP_WTX, 32'hE1, OP_WCTL, 32'h8, "R10");
        step(OP_IDLE, 0, OP_RRX, 0, "R10");
        step(OP_IDLE, 0, OP_RCTL, 0, "R10");
        step(OP_IDLE, 0, OP_WCTL, 32'h5, "R10");
        step(OP_IDLE, 0, OP_RRX, 0, "R10");

        // R2: random two-sided traffic against the model
        step(OP_WCTL, 32'h7, OP_WCTL, 32'h7, "R2");
        for (int i = 0; i < 3000; i++) begin
            int          op[2];
            logic [31:0] d[2];
            for (int s = 0; s < 2; s++) begin
                int r = $urandom_range(0, 99);
                d[s] = $urandom;
                if (r < 35)      op[s] = OP_WTX;
                else if (r < 68) op[s] = OP_RRX;
                else if (r < 80) op[s] = OP_RCTL;
                else if (r < 84) begin
                    op[s] = OP_WCTL;
                    d[s] = {27'b0, ($urandom_range(0, 3) == 0), d[s][3:1],
                            ($urandom_range(0, 7) != 0)};
                end
                else if (r < 87) op[s] = OP_R3;
                else             op[s] = OP_IDLE;
            end
            step(op[0], d[0], op[1], d[1], "R2");
        end
        repeat (3) step(OP_IDLE, 0, OP_IDLE, 0, "R8");
        finish_run();
    end

endmodule